// File: doc/BRIEF.md
# Gray-Coded Counter Clock-Domain Transfer

This block keeps a free-running binary counter in a source clock domain and makes its value readable in a destination clock domain whose clock has no fixed relation to the source clock. A typical pairing is a 50 MHz counter read by 77 MHz logic. If the destination sampled the binary count directly, a capture that lands on a step such as 0x7F to 0x80 could pick up some old bits and some new bits. The result would be a value that never existed.

Every value that crosses is first recoded so that consecutive counts differ in a single bit. The recoding is done from the counter's next-state value, and the result is stored in a source-clock flop. The crossing wires therefore carry no glitches from the XOR network. In the destination domain a chain of at least two flops per bit receives the word. The word is then decoded back to binary and can optionally be registered once more. A capture that meets a changing bit therefore returns either the old count or the new one.

Top module: `gray_count_xfer`

## Requirements
- R1: While either reset is asserted (active low), that domain's state is zero. `dst_count` reads 0 during destination reset, and the counter reads 0 when source reset is released.
- R2: On each rising `src_clk` edge with `cnt_en` high, the source count advances by exactly one modulo 2^WIDTH. With `cnt_en` low, it holds its value.
- R3: The word that crosses domains is the reflected Gray code of the current source count, taken from a source-clock register. Bit i is count[i] XOR count[i+1], and the top bit equals the count's top bit. Successive register values differ in at most one bit.
- R4: The destination passes each crossing bit through SYNC_STAGES flops (at least 2) before decoding. The decode is binary[WIDTH-1] = gray[WIDTH-1] and binary[i] = binary[i+1] XOR gray[i].
- R5: Every destination value equals some source count that existed within the last five destination clock periods. No mixed or corrupted value ever appears.
- R6: When the destination clock is faster than the source clock, `dst_count` never moves backwards (modulo 2^WIDTH). It also advances by at most one between consecutive destination clock edges.
- R7: After `cnt_en` has been low long enough for the last change to pass the synchronizer (SYNC_STAGES + 2 destination cycles), `dst_count` equals the source count exactly.
- R8: The all-bits-change steps 0x7F to 0x80 and 0xFF to 0x00 (WIDTH = 8) arrive in the destination as one clean step. No intermediate value appears between the two counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| cnt_en | input | 1 | Count enable, sampled on src_clk |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_count | output | WIDTH | Binary count as seen in the destination domain |

## Verification
The bench runs the two clocks at a 50:77 period ratio with a random phase offset. It drives random enable bursts so that captures keep landing near source edges. A design that sent the binary count across, or decoded the Gray word with a wrong XOR chain, would show values outside the recent-count window or backward steps. The bench deliberately runs the count through 0x7F→0x80 and the full wrap, the two places where an unregistered or wrongly encoded word would produce the worst corruption. It also stops the count, waits, and compares for exact equality. A missing or off-by-one increment in the source counter then shows up as a fixed offset.

// File: rtl/gcx_pkg.sv
package gcx_pkg;
   parameter int unsigned GCX_MIN_WIDTH  = 2;
   parameter int unsigned GCX_MIN_STAGES = 2;

   typedef enum logic {
      GCX_OUT_DIRECT = 1'b0,
      GCX_OUT_FLOP   = 1'b1
   } gcx_out_mode_e;
endpackage

// File: rtl/gcx_src_counter.sv
module gcx_src_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [WIDTH-1:0] gray_q
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   logic [WIDTH-1:0] gray_d;

   always_comb cnt_d = en ? cnt_q + ONE : cnt_q;

   // Encode the next count, so the crossing register always holds code(cnt_q).
   generate
      for (genvar i = 0; i < WIDTH - 1; i++) begin : g_enc
         assign gray_d[i] = cnt_d[i] ^ cnt_d[i+1];
      end
   endgenerate
   assign gray_d[WIDTH-1] = cnt_d[WIDTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         gray_q <= '0;
      end else begin
         cnt_q  <= cnt_d;
         gray_q <= gray_d;
      end
   end

   assert_reset_zero_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cnt_q == '0 && gray_q == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> cnt_q == $past(cnt_q) + ONE);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));

   assert_gray_onebit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q == '1) |=> cnt_q == '0);
endmodule

// File: rtl/gcx_sync.sv
module gcx_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[LAST];

   assert_sync_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> q == '0);
endmodule

// File: rtl/gcx_gray2bin.sv
module gcx_gray2bin #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] gray,
   output logic [WIDTH-1:0] bin
);
   assign bin[WIDTH-1] = gray[WIDTH-1];
   generate
      for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_dec
         assign bin[i] = bin[i+1] ^ gray[i];
      end
   endgenerate
endmodule

// File: rtl/gray_count_xfer.sv
module gray_count_xfer #(
   parameter int unsigned           WIDTH       = 8,
   parameter int unsigned           SYNC_STAGES = 2,
   parameter gcx_pkg::gcx_out_mode_e OUT_MODE   = gcx_pkg::GCX_OUT_FLOP
) (
   input  logic             src_clk,
   input  logic             src_rst_n,
   input  logic             cnt_en,
   input  logic             dst_clk,
   input  logic             dst_rst_n,
   output logic [WIDTH-1:0] dst_count
);
   import gcx_pkg::*;

   generate
      if (WIDTH < GCX_MIN_WIDTH) begin : g_bad_width
         $error("gray_count_xfer: WIDTH below minimum");
      end
      if (SYNC_STAGES < GCX_MIN_STAGES) begin : g_bad_stages
         $error("gray_count_xfer: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [WIDTH-1:0] src_gray;
   logic [WIDTH-1:0] dst_gray;
   logic [WIDTH-1:0] dst_bin;

   gcx_src_counter #(.WIDTH(WIDTH)) u_src (
      .clk    (src_clk),
      .rst_n  (src_rst_n),
      .en     (cnt_en),
      .gray_q (src_gray)
   );

   gcx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d     (src_gray),
      .q     (dst_gray)
   );

   gcx_gray2bin #(.WIDTH(WIDTH)) u_dec (
      .gray (dst_gray),
      .bin  (dst_bin)
   );

   generate
      if (OUT_MODE == GCX_OUT_FLOP) begin : g_out_flop
         logic [WIDTH-1:0] out_q;
         always_ff @(posedge dst_clk or negedge dst_rst_n) begin
            if (!dst_rst_n) out_q <= '0;
            else            out_q <= dst_bin;
         end
         assign dst_count = out_q;
      end else begin : g_out_direct
         assign dst_count = dst_bin;
      end
   endgenerate

   assert_dst_reset_R1: assert property (@(posedge dst_clk)
      !dst_rst_n |=> dst_count == '0 || dst_rst_n);
endmodule

// File: tb/gray_count_xfer_test.sv
`timescale 1ns/1ps
module gray_count_xfer_test;
   localparam int unsigned W = 8;
   localparam realtime DST_HALF = 2.0;    // 250 MHz destination
   localparam realtime SRC_HALF = 3.08;   // 50:77 period ratio

   logic src_clk = 1'b0, dst_clk = 1'b0;
   logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
   logic cnt_en = 1'b0;
   logic [W-1:0] dst_count;

   int tests = 0, fails = 0;
   int unsigned model = 0;          // unwrapped source count
   int unsigned hist [8];
   int unsigned hidx = 0;
   logic [W-1:0] prev_out = '0;
   bit checking = 0, finished = 0, hit_7f = 0, hit_ff = 0;
   realtime phase;

   gray_count_xfer #(.WIDTH(W)) uut (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .cnt_en(cnt_en),
      .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(dst_count)
   );

   initial forever #DST_HALF dst_clk = ~dst_clk;
   initial begin
      phase = real'($urandom_range(1, 997)) / 100.0;
      #phase;
      forever #SRC_HALF src_clk = ~src_clk;
   end

   // Reference count: advances on every enabled source edge.
   always @(posedge src_clk) if (src_rst_n && cnt_en) model <= model + 1;

   function automatic bit in_window(input logic [W-1:0] v, input int unsigned lo,
                                    input int unsigned hi);
      logic [W-1:0] d;
      d = v - lo[W-1:0];
      return (int'(d) <= int'(hi - lo));
   endfunction

   task automatic check(input bit ok, input string req, input int unsigned act,
                        input int unsigned exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // Continuous checks at every destination falling edge.
   always @(negedge dst_clk) begin
      if (checking) begin
         int unsigned lo;
         logic [W-1:0] step;
         lo = hist[(hidx + 3) % 8];  // five samples back
         check(in_window(dst_count, lo, model), "R5 R3 window", dst_count, model);
         step = dst_count - prev_out;
         check(step <= 1, "R6 R4 step", dst_count, prev_out);
         if (prev_out == 8'h7f && dst_count != prev_out) begin
            hit_7f = 1;
            check(dst_count == 8'h80, "R8 7f->80", dst_count, 8'h80);
         end
         if (prev_out == 8'hff && dst_count != prev_out) begin
            hit_ff = 1;
            check(dst_count == 8'h00, "R8 ff->00", dst_count, 8'h00);
         end
      end
      hist[hidx] = model;
      hidx = (hidx + 1) % 8;
      prev_out = dst_count;
   end

   task automatic settle_and_compare(input string req);
      @(negedge src_clk) cnt_en = 1'b0;
      repeat (10) @(negedge dst_clk);
      check(dst_count == model[W-1:0], req, dst_count, model[W-1:0]);
   endtask

   task automatic run_enabled(input int unsigned n);
      repeat (n) @(negedge src_clk) cnt_en = 1'b1;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge dst_clk);
      check(dst_count == '0, "R1 in reset", dst_count, 0);
      @(negedge src_clk) src_rst_n = 1'b1;
      repeat (2) @(negedge dst_clk);
      dst_rst_n = 1'b1;
      repeat (6) @(negedge dst_clk);
      check(dst_count == '0, "R1 after release", dst_count, 0);
      for (int i = 0; i < 8; i++) hist[i] = 0;
      checking = 1;

      // Directed: walk across 0x7F->0x80, stop just past it, compare exactly
      run_enabled(130);
      settle_and_compare("R7 R2 after 0x80");
      // Directed: walk across the wrap
      run_enabled(130);
      settle_and_compare("R7 R8 after wrap");

      // Constrained random bursts
      for (int b = 0; b < 60; b++) begin
         int unsigned len;
         len = $urandom_range(3, 150);
         for (int k = 0; k < int'(len); k++) begin
            @(negedge src_clk) cnt_en = ($urandom_range(0, 3) != 0);
         end
         if (b % 6 == 5) settle_and_compare("R7 R2 random hold");
      end
      settle_and_compare("R7 R2 final");

      check(hit_7f, "R8 0x7f step seen", hit_7f, 1);
      check(hit_ff, "R8 0xff step seen", hit_ff, 1);
      checking = 0;
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400us;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule